// File: doc/BRIEF.md
# Cross-Processor Handshake Sync Register

Two processors share this block. Each one sees its own 32-bit handshake register at a single bus address. A processor writes a 4-bit status value into its register, and the other processor reads that value back in a read-only field of its own register. Either side can also ring a doorbell. The doorbell is a write-only bit that raises an interrupt on the other processor, but only when that processor has turned its doorbell enable on.

Each side has a write strobe with 32-bit data and four byte enables. Each side also has a read-data output that always shows the current state of that side's register. A one-bit interrupt output goes to that side's own interrupt controller.

Register layout, the same on both sides:
- Bits 3:0 hold the peer's status nibble. This field is read-only.
- Bits 11:8 hold this side's status nibble. This field is read/write.
- Bit 13 is the doorbell. It is write-only.
- Bit 14 is the doorbell enable. It is read/write.

All of the fields except bits 3:0 lie in byte lane 1 (bits 15:8).

Top module: `xsync_top`

## Requirements
- R1: After reset, both read-data outputs are 0 and both interrupt outputs are 0.
- R2: Bits 11:8 of a side's register hold the last value that side wrote there, and they read back unchanged until that side writes byte lane 1 again.
- R3: Bits 3:0 of a side's read data equal bits 11:8 of the peer's register, starting in the cycle after the peer's write. Writes to bits 3:0 have no effect.
- R4: Bit 13 always reads 0. A side may write 1 to bit 13 with byte lane 1 enabled while the peer's bit 14 is 1. In that case the peer's interrupt output is 1 for exactly the one cycle after the write edge.
- R5: A doorbell written while the peer's bit 14 is 0 is dropped. No pulse occurs, and none occurs later when the enable is set.
- R6: Bit 14 is read/write and holds the value last written through byte lane 1.
- R7: Bits 31:16, 15, 12 and 7:4 always read 0, and writes to them are ignored.
- R8: Only byte lanes whose enable is 1 are written. A write with lane 1 disabled leaves the nibble and the enable unchanged and does not ring the doorbell.
- R9: When both sides write in the same cycle, both writes take effect, and each side sees the peer's new nibble in the next cycle.
- R10: A doorbell never asserts the writing side's own interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_a | input | 1 | Side A write strobe |
| wdata_a | input | 32 | Side A write data |
| be_a | input | 4 | Side A byte enables |
| rdata_a | output | 32 | Side A register read data |
| irq_a | output | 1 | Side A doorbell interrupt pulse |
| wr_b | input | 1 | Side B write strobe |
| wdata_b | input | 32 | Side B write data |
| be_b | input | 4 | Side B byte enables |
| rdata_b | output | 32 | Side B register read data |
| irq_b | output | 1 | Side B doorbell interrupt pulse |

## Verification
Nibble writes go first from one side, then from the other, and then from both in the same cycle. This separates correct cross-wiring from a swapped or lost update. Doorbells are rung with the peer enable on and with it off, and the peer then enables afterwards. This tells a gated single-cycle pulse apart from a latched or ungated one. Full-word writes with every bit set, and writes with byte lane 1 masked off, show whether the read-only, reserved and byte-enable rules hold.

// File: rtl/xsync_pkg.sv
package xsync_pkg;
    localparam int REG_W   = 32;
    localparam int NIB_W   = 4;
    localparam int LANE_W  = 8;
    localparam int N_LANE  = REG_W / LANE_W;
    localparam int IN_LSB  = 0;
    localparam int OUT_LSB = 8;
    localparam int DB_BIT  = 13;
    localparam int EN_BIT  = 14;
    localparam int CTL_LANE = OUT_LSB / LANE_W;
    localparam int OUT_OFS = OUT_LSB - CTL_LANE * LANE_W;
    localparam int DB_OFS  = DB_BIT - CTL_LANE * LANE_W;
    localparam int EN_OFS  = EN_BIT - CTL_LANE * LANE_W;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             en;
        logic             irq;
    } side_t;
endpackage

// File: rtl/xsync_wdec.sv
module xsync_wdec
    import xsync_pkg::*;
(
    input  logic              wr,
    input  logic              lane_be,
    input  logic [LANE_W-1:0] lane,
    input  logic [NIB_W-1:0]  cur_nib,
    input  logic              cur_en,
    output logic [NIB_W-1:0]  nxt_nib,
    output logic              nxt_en,
    output logic              ring
);
    logic hit;

    always_comb begin
        hit     = wr && lane_be;
        nxt_nib = hit ? lane[OUT_OFS +: NIB_W] : cur_nib;
        nxt_en  = hit ? lane[EN_OFS] : cur_en;
        ring    = hit && lane[DB_OFS];
    end
endmodule

// File: rtl/xsync_rmux.sv
module xsync_rmux
    import xsync_pkg::*;
(
    input  logic [NIB_W-1:0] own_nib,
    input  logic             own_en,
    input  logic [NIB_W-1:0] peer_nib,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        rdata[IN_LSB  +: NIB_W] = peer_nib;
        rdata[OUT_LSB +: NIB_W] = own_nib;
        rdata[EN_BIT]           = own_en;
    end
endmodule

// File: rtl/xsync_top.sv
module xsync_top
    import xsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic [REG_W-1:0]  wdata_a,
    input  logic [N_LANE-1:0] be_a,
    output logic [REG_W-1:0]  rdata_a,
    output logic              irq_a,
    input  logic              wr_b,
    input  logic [REG_W-1:0]  wdata_b,
    input  logic [N_LANE-1:0] be_b,
    output logic [REG_W-1:0]  rdata_b,
    output logic              irq_b
);
    localparam int NS = 2;

    side_t st_d [NS];
    side_t st_q [NS];

    logic [NS-1:0]             wr_v;
    logic [NS-1:0]             be_v;
    logic [LANE_W-1:0]         lane_v [NS];
    logic [NIB_W-1:0]          nib_n  [NS];
    logic [NS-1:0]             en_n;
    logic [NS-1:0]             ring_v;
    logic [REG_W-1:0]          rd_v   [NS];

    always_comb begin
        wr_v[0]   = wr_a;
        wr_v[1]   = wr_b;
        be_v[0]   = be_a[CTL_LANE];
        be_v[1]   = be_b[CTL_LANE];
        lane_v[0] = wdata_a[CTL_LANE*LANE_W +: LANE_W];
        lane_v[1] = wdata_b[CTL_LANE*LANE_W +: LANE_W];
    end

    for (genvar s = 0; s < NS; s++) begin : g_side
        xsync_wdec u_wdec (
            .wr      (wr_v[s]),
            .lane_be (be_v[s]),
            .lane    (lane_v[s]),
            .cur_nib (st_q[s].nib),
            .cur_en  (st_q[s].en),
            .nxt_nib (nib_n[s]),
            .nxt_en  (en_n[s]),
            .ring    (ring_v[s])
        );
        xsync_rmux u_rmux (
            .own_nib  (st_q[s].nib),
            .own_en   (st_q[s].en),
            .peer_nib (st_q[NS-1-s].nib),
            .rdata    (rd_v[s])
        );
    end

    // next-state: doorbell from the peer is gated by this side's current enable
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            st_d[s].nib = nib_n[s];
            st_d[s].en  = en_n[s];
            st_d[s].irq = ring_v[NS-1-s] && st_q[s].en;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) st_q[s] <= '0;
            else        st_q[s] <= st_d[s];
        end
    end

    assign rdata_a = rd_v[0];
    assign rdata_b = rd_v[1];
    assign irq_a   = st_q[0].irq;
    assign irq_b   = st_q[1].irq;
endmodule

// File: rtl/xsync_chk.sv
module xsync_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_a,
    input logic        be1_a,
    input logic        db_a,
    input logic        wr_b,
    input logic        be1_b,
    input logic        db_b,
    input logic [31:0] rdata_a,
    input logic [31:0] rdata_b,
    input logic        irq_a,
    input logic        irq_b
);
    logic ring_a, ring_b;
    assign ring_a = wr_a && be1_a && db_a;
    assign ring_b = wr_b && be1_b && db_b;

    a_r4_ring_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_a && rdata_b[14]) |=> irq_b);
    a_r4_ring_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_b && rdata_a[14]) |=> irq_a);
    a_r5_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_a && rdata_b[14]) |=> !irq_b);
    a_r5_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_b && rdata_a[14]) |=> !irq_a);
    a_r3_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_a[3:0] == rdata_b[11:8]) && (rdata_b[3:0] == rdata_a[11:8]));
    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_a & ~32'h0000_4F0F) == 32'h0) && ((rdata_b & ~32'h0000_4F0F) == 32'h0));
    a_r2_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_a && be1_a) |=> $stable(rdata_a[14:8]));
    a_r2_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_b && be1_b) |=> $stable(rdata_b[14:8]));
endmodule

bind xsync_top xsync_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a    (wr_a),
    .be1_a   (be_a[1]),
    .db_a    (wdata_a[13]),
    .wr_b    (wr_b),
    .be1_b   (be_b[1]),
    .db_b    (wdata_b[13]),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b),
    .irq_a   (irq_a),
    .irq_b   (irq_b)
);

// File: tb/sim_xsync_top.sv
module sim_xsync_top;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_a = 0, wr_b = 0;
    logic [31:0] wdata_a = 0, wdata_b = 0;
    logic [3:0]  be_a = 0, be_b = 0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    xsync_top u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge; after return the write edge has passed
    task automatic wr2(bit ea, logic [31:0] da, logic [3:0] ba,
                       bit eb, logic [31:0] db, logic [3:0] bb);
        wr_a = ea; wdata_a = da; be_a = ba;
        wr_b = eb; wdata_b = db; be_b = bb;
        @(negedge clk);
        wr_a = 0; wr_b = 0; wdata_a = 0; wdata_b = 0; be_a = 0; be_b = 0;
    endtask

    task automatic wra(logic [31:0] d, logic [3:0] b); wr2(1, d, b, 0, 0, 0); endtask
    task automatic wrb(logic [31:0] d, logic [3:0] b); wr2(0, 0, 0, 1, d, b); endtask

    task automatic t_reset;
        check("R1 rdata_a", rdata_a, 0);
        check("R1 rdata_b", rdata_b, 0);
        check("R1 irqs", {irq_a, irq_b}, 0);
    endtask

    task automatic t_nibble;
        wra(32'h0000_0A00, 4'h2);
        check("R2 own nibble A", rdata_a, 32'h0000_0A00);
        check("R3 peer nibble at B", rdata_b, 32'h0000_000A);
        wrb(32'h0000_0500, 4'h2);
        check("R3 peer nibble at A", rdata_a, 32'h0000_0A05);
        check("R2 own nibble B", rdata_b, 32'h0000_050A);
    endtask

    task automatic t_ro_reserved;
        wra(32'hFFFF_00FF, 4'hF);
        check("R3 R7 ro and reserved", rdata_a, 32'h0000_0005);
        wra(32'hFFFF_BFFF, 4'hF);
        check("R7 R4 full write", rdata_a, 32'h0000_0F05);
        check("R5 dropped irq_b", irq_b, 0);
        @(negedge clk);
        check("R5 still none", irq_b, 0);
    endtask

    task automatic t_doorbell;
        wrb(32'h0000_4500, 4'h2);
        check("R6 enable B", rdata_b, 32'h0000_450F);
        wra(32'h0000_2F00, 4'h2);
        check("R4 pulse irq_b", irq_b, 1);
        check("R10 no own irq_a", irq_a, 0);
        check("R4 db reads 0", rdata_a, 32'h0000_0F05);
        @(negedge clk);
        check("R4 single cycle", irq_b, 0);
    endtask

    task automatic t_drop;
        wrb(32'h0000_0500, 4'h2);
        check("R6 disable B", rdata_b, 32'h0000_050F);
        wra(32'h0000_2F00, 4'h2);
        check("R5 gated off", irq_b, 0);
        wrb(32'h0000_4500, 4'h2);
        check("R5 not held", irq_b, 0);
        @(negedge clk);
        check("R5 not held later", irq_b, 0);
    endtask

    task automatic t_bytes;
        wra(32'hFFFF_FF00, 4'hD);
        check("R8 lane1 masked", rdata_a, 32'h0000_0F05);
        check("R8 no ring", irq_b, 0);
        wra(32'h0000_4300, 4'h2);
        check("R8 R6 byte write", rdata_a, 32'h0000_4305);
    endtask

    task automatic t_simul;
        wr2(1, 32'h0000_0C00, 4'h2, 1, 32'h0000_0900, 4'h2);
        check("R9 side A", rdata_a, 32'h0000_0C09);
        check("R9 side B", rdata_b, 32'h0000_090C);
        wr2(1, 32'h0000_4C00, 4'h2, 1, 32'h0000_4900, 4'h2);
        wr2(1, 32'h0000_6C00, 4'h2, 1, 32'h0000_6900, 4'h2);
        check("R9 R4 both pulse", {irq_a, irq_b}, 2'b11);
        @(negedge clk);
        check("R4 both end", {irq_a, irq_b}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_nibble();
        t_ro_reserved();
        t_doorbell();
        t_drop();
        t_bytes();
        t_simul();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule